// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire bus target that sits in front of a byte-wide nonvolatile memory model of up to 2048 bytes, held in a register array. A host opens each transfer with a START condition and then sends an address byte. The upper nibble of that byte selects the device. The next three bits carry the high memory address bits. The last bit chooses the direction. The block supports single-byte and page writes, current-address reads, random reads and sequential reads.

Write data collects in a 16-byte page buffer. The buffer is committed to the array when the STOP condition arrives. After that the block spends a fixed number of clocks in an internal write cycle. During this cycle it refuses its own address, so a host can find out when the cycle has ended by repeatedly sending the address and waiting for an acknowledge.

A write-protect pin and a supply-lockout flag block data writes. The bus lines reach the block already synchronized to its clock. The block drives the data line only through a pull-down enable.

Top module: `serial_nvm_slave`

## Requirements
- R1: An address byte is acknowledged only when its bits [7:4] equal 1010 and no write cycle is running. Otherwise the block does not acknowledge and ignores everything until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A byte clocked in without a preceding START gets no acknowledge.
- R3: The block acknowledges by pulling SDA low during the ninth SCL clock of a byte. It does this for a matching address byte, for the memory address byte of a write, and for each accepted data byte. It pulls SDA only during these acknowledge phases and while sending read data, and after reset it pulls nothing.
- R4: In a write, each accepted data byte goes to the current pointer, and then only the low 4 pointer bits increment. Bytes past the 16th wrap inside the same 16-byte page and overwrite the earlier ones.
- R5: A STOP that follows at least one accepted data byte commits the page buffer and holds busy_o high for WRITE_CYCLES clocks. While busy_o is high, address bytes are not acknowledged. Data read after the cycle ends is the new data.
- R6: With wp_i high, the block still acknowledges the address byte and the memory address byte. It does not acknowledge the data byte, stores nothing and starts no write cycle.
- R7: With lockout_i high, data bytes are refused exactly as in R6.
- R8: A read without a preceding address setup starts at the pointer, which holds the last accessed address plus one. The pointer increments across all address bits during reads and wraps from 2047 to 0. The three middle bits of a read-mode address byte do not change the pointer.
- R9: A write-mode address byte followed by a memory address byte sets the pointer to {address byte bits [3:1], memory address byte}. A repeated START with a read-mode address byte then reads from that location.
- R10: In a read, a host acknowledge (SDA low on the ninth clock) makes the block send the next byte. A host non-acknowledge makes it release SDA and wait for STOP.
- R11: A STOP with no accepted data byte starts no write cycle, and busy_o stays low. After reset busy_o is low.
- R12: SDA is changed only while SCL is low and is sampled on SCL rising, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line (wired level) |
| wp_i | input | 1 | Write protect, high blocks data writes |
| lockout_i | input | 1 | Supply below threshold, high blocks data writes |
| sda_pull_o | output | 1 | High pulls the data line low |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench goes after page wraparound with 18 to 20 bytes written from an offset near the page end. A design that carried the increment into the page bits would scatter the data into the next page. Reads that cross address 2047 catch a pointer that saturates or wraps only within a page. Host ACK polling right after a commit catches a block that answers during its write cycle, and the same check also catches one whose cycle never ends. Write protect, supply lockout and an address-only write must all leave both the memory and busy_o untouched; a design that still stored the byte or started a cycle would show the stale data or a busy flag.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADR,
        ST_ADR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_HOLD
    } ctl_state_e;

    localparam logic [3:0] DEV_ID = 4'b1010;

endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic scl;
        logic sda;
    } line_hist_t;

    line_hist_t hist_d, hist_q;

    always_comb begin
        hist_d     = hist_q;
        hist_d.scl = scl_i;
        hist_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            hist_q <= hist_d;
        end
    end

    assign scl_rise_o = scl_i & ~hist_q.scl;
    assign scl_fall_o = ~scl_i & hist_q.scl;
    // SDA edges while SCL stays high mark the bus conditions
    assign start_o    = scl_i & hist_q.scl & hist_q.sda & ~sda_i;
    assign stop_o     = scl_i & hist_q.scl & ~hist_q.sda & sda_i;

endmodule

// File: rtl/wr_busy_timer.sv
module wr_busy_timer #(
    parameter int WRITE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(WRITE_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(WRITE_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i)); // R5

endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
    parameter int MEM_BYTES  = 2048,
    parameter int PAGE_BYTES = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      buf_we_i,
    input  logic [$clog2(PAGE_BYTES)-1:0]             buf_idx_i,
    input  logic [7:0]                                buf_data_i,
    input  logic                                      commit_i,
    input  logic [$clog2(MEM_BYTES)-$clog2(PAGE_BYTES)-1:0] page_i,
    input  logic [$clog2(MEM_BYTES)-1:0]              rd_addr_i,
    output logic [7:0]                                rd_data_o
);

    localparam int PG_W = $clog2(PAGE_BYTES);

    logic [7:0]            mem_q  [MEM_BYTES];
    logic [7:0]            pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvld_q;

    // Array and page buffer are plain storage; erased state is all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                mem_q[i] <= 8'hFF;
            end
            for (int j = 0; j < PAGE_BYTES; j++) begin
                pbuf_q[j] <= 8'h00;
            end
            pvld_q <= '0;
        end else if (commit_i) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (pvld_q[i]) begin
                    mem_q[{page_i, PG_W'(i)}] <= pbuf_q[i];
                end
            end
            pvld_q <= '0;
        end else if (buf_we_i) begin
            pbuf_q[buf_idx_i] <= buf_data_i;
            pvld_q[buf_idx_i] <= 1'b1;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

    AST_COMMIT_NOT_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_i && buf_we_i)); // R5

endmodule

// File: rtl/serial_nvm_slave.sv
module serial_nvm_slave #(
    parameter int MEM_BYTES    = 2048,
    parameter int PAGE_BYTES   = 16,
    parameter int WRITE_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    input  logic lockout_i,
    output logic sda_pull_o,
    output logic busy_o
);

    import nvm_pkg::*;

    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int HI_W   = ADDR_W - 8;
    localparam int PG_W   = $clog2(PAGE_BYTES);
    localparam int PGN_W  = ADDR_W - PG_W;

    typedef struct packed {
        ctl_state_e        state;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic              pull;
        logic              rw;
        logic              host_ack;
        logic [HI_W-1:0]   hi;
        logic [ADDR_W-1:0] addr;
        logic [PGN_W-1:0]  page;
        logic              have_data;
    } ctl_t;

    ctl_t q, d;

    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic buf_we, commit;
    logic [PG_W-1:0] buf_idx;
    logic [7:0] buf_data, rd_data;
    logic busy;

    i2c_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    wr_busy_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit),
        .busy_o  (busy)
    );

    nvm_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .buf_we_i   (buf_we),
        .buf_idx_i  (buf_idx),
        .buf_data_i (buf_data),
        .commit_i   (commit),
        .page_i     (q.page),
        .rd_addr_i  (q.addr),
        .rd_data_o  (rd_data)
    );

    logic rx_state, byte_in;
    assign rx_state = (q.state == ST_DEV) || (q.state == ST_ADR) || (q.state == ST_WR);
    assign byte_in  = scl_fall && (q.cnt == 4'd8);

    always_comb begin
        d        = q;
        buf_we   = 1'b0;
        buf_idx  = q.addr[PG_W-1:0];
        buf_data = q.sh;
        commit   = 1'b0;

        if (bus_stop) begin
            d.state     = ST_IDLE;
            d.pull      = 1'b0;
            d.cnt       = 4'd0;
            commit      = q.have_data;
            d.have_data = 1'b0;
        end else if (bus_start) begin
            d.state = ST_DEV;
            d.pull  = 1'b0;
            d.cnt   = 4'd0;
        end else begin
            if (rx_state && scl_rise) begin
                d.sh  = {q.sh[6:0], sda_i};
                d.cnt = q.cnt + 4'd1;
            end
            case (q.state)
                ST_DEV: begin
                    if (byte_in) begin
                        d.cnt = 4'd0;
                        if ((q.sh[7:4] == DEV_ID) && !busy) begin
                            d.pull  = 1'b1;
                            d.rw    = q.sh[0];
                            d.hi    = q.sh[HI_W:1];
                            d.state = ST_DEV_ACK;
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_ADR: begin
                    if (byte_in) begin
                        d.cnt   = 4'd0;
                        d.addr  = {q.hi, q.sh};
                        d.pull  = 1'b1;
                        d.state = ST_ADR_ACK;
                    end
                end
                ST_WR: begin
                    if (byte_in) begin
                        d.cnt = 4'd0;
                        if (wp_i || lockout_i) begin
                            d.state = ST_HOLD;
                        end else begin
                            buf_we               = 1'b1;
                            d.page               = q.addr[ADDR_W-1:PG_W];
                            d.addr[PG_W-1:0]     = q.addr[PG_W-1:0] + PG_W'(1);
                            d.have_data          = 1'b1;
                            d.pull               = 1'b1;
                            d.state              = ST_WR_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        if (q.rw) begin
                            d.sh    = rd_data;
                            d.addr  = q.addr + ADDR_W'(1);
                            d.pull  = ~rd_data[7];
                            d.cnt   = 4'd0;
                            d.state = ST_RD;
                        end else begin
                            d.pull  = 1'b0;
                            d.state = ST_ADR;
                        end
                    end
                end
                ST_ADR_ACK, ST_WR_ACK: begin
                    if (scl_fall) begin
                        d.pull  = 1'b0;
                        d.state = ST_WR;
                    end
                end
                ST_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.pull  = 1'b0;
                            d.cnt   = 4'd0;
                            d.state = ST_RD_ACK;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.pull = ~q.sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        d.host_ack = ~sda_i;
                    end else if (scl_fall) begin
                        if (q.host_ack) begin
                            d.sh    = rd_data;
                            d.addr  = q.addr + ADDR_W'(1);
                            d.pull  = ~rd_data[7];
                            d.cnt   = 4'd0;
                            d.state = ST_RD;
                        end else begin
                            d.state = ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o = q.pull;
    assign busy_o     = busy;

    AST_PULL_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pull != $past(q.pull)) |-> !scl_i); // R12

    AST_PULL_ONLY_ACK_OR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        q.pull |-> (q.state inside {ST_DEV_ACK, ST_ADR_ACK, ST_WR_ACK, ST_RD})); // R3

    AST_NO_ADDR_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_DEV_ACK) && ($past(q.state) != ST_DEV_ACK)) |-> !$past(busy)); // R5

    AST_NO_STORE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_WR_ACK) && ($past(q.state) == ST_WR)) |-> (!$past(wp_i) && !$past(lockout_i))); // R6

endmodule

// File: tb/sim_serial_nvm_slave.sv
module sim_serial_nvm_slave;

    localparam int MEMB = 2048;
    localparam int H    = 8;
    localparam int WCYC = 200;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic lock = 1'b0;
    logic pull, busy;
    logic sda_line;
    assign sda_line = m_sda & ~pull;

    serial_nvm_slave #(.MEM_BYTES(MEMB), .PAGE_BYTES(16), .WRITE_CYCLES(WCYC)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .wp_i       (wp),
        .lockout_i  (lock),
        .sda_pull_o (pull),
        .busy_o     (busy)
    );

    int checks = 0;
    int errors = 0;
    int viol   = 0;
    logic [7:0] mem_m [MEMB];
    int ptr_m = 0;
    logic prev_pull = 1'b0;

    // R12: pull-down may only move while SCL is low
    always @(negedge clk) begin
        if (rst_n && (pull != prev_pull) && m_scl) viol++;
        prev_pull <= pull;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int page_pos(input int base, input int k);
        return (base & ~15) | ((base + k) & 15);
    endfunction

    task automatic start_c();
        m_sda = 1'b1; wt(H/2);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b0; wt(H);
        m_scl = 1'b0; wt(H/2);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; wt(H/2);
        m_scl = 1'b1; wt(H);
        m_sda = 1'b1; wt(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(H/2);
            m_scl = 1'b1; wt(H);
            m_scl = 1'b0; wt(H/2);
        end
        m_sda = 1'b1; wt(H/2);
        m_scl = 1'b1; wt(H/2);
        ack = ~sda_line;
        wt(H/2);
        m_scl = 1'b0; wt(H/2);
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        b = 8'h00;
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wt(H/2);
            m_scl = 1'b1; wt(H/2);
            b = {b[6:0], sda_line};
            wt(H/2);
            m_scl = 1'b0;
        end
        wt(H/2);
        m_sda = ~mack; wt(H/2);
        m_scl = 1'b1; wt(H);
        m_scl = 1'b0; wt(H/2);
        m_sda = 1'b1;
    endtask

    task automatic do_write(input int addr, input int n, input bit wpv, input bit lk);
        bit a;
        int acc;
        logic [10:0] a11;
        logic [7:0] b;
        a11 = addr[10:0];
        acc = 0;
        wp = wpv; lock = lk;
        start_c();
        send_byte({4'hA, a11[10:8], 1'b0}, a);
        chk(a, "R3 write address ack", int'(a), 1);
        send_byte(a11[7:0], a);
        chk(a, "R3 memory address ack", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            b = 8'($urandom);
            send_byte(b, a);
            if (wpv) chk(a == 1'b0, "R6 protected data nack", int'(a), 0);
            else if (lk) chk(a == 1'b0, "R7 lockout data nack", int'(a), 0);
            else chk(a == 1'b1, "R3 data ack", int'(a), 1);
            if (!a) break;
            mem_m[page_pos(addr, i)] = b;
            acc++;
        end
        stop_c();
        ptr_m = (acc > 0) ? page_pos(addr, acc) : addr;
        if (acc > 0) begin
            chk(busy == 1'b1, "R5 busy after commit", int'(busy), 1);
        end else if (wpv) begin
            chk(busy == 1'b0, "R6 no cycle when protected", int'(busy), 0);
        end else begin
            chk(busy == 1'b0, "R7 no cycle under lockout", int'(busy), 0);
        end
        wp = 1'b0; lock = 1'b0;
        if (acc > 0) begin
            int polls;
            bit ok;
            polls = 0;
            ok = 1'b0;
            for (int k = 0; k < 40 && !ok; k++) begin
                start_c();
                send_byte(8'hA0, ok);
                stop_c();
                if (!ok) polls++;
            end
            chk(polls >= 1, "R5 address refused while busy", polls, 1);
            chk(ok, "R5 ready after write cycle", int'(ok), 1);
        end
    endtask

    task automatic do_read(input bit rnd, input int addr, input int n);
        bit a;
        logic [10:0] a11;
        logic [7:0] b;
        logic [7:0] e;
        a11 = addr[10:0];
        start_c();
        if (rnd) begin
            send_byte({4'hA, a11[10:8], 1'b0}, a);
            chk(a, "R9 setup address ack", int'(a), 1);
            send_byte(a11[7:0], a);
            chk(a, "R9 setup memory address ack", int'(a), 1);
            ptr_m = addr;
            start_c();
        end
        send_byte({4'hA, 3'($urandom), 1'b1}, a);
        chk(a, "R8 read address ack", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            e = mem_m[(ptr_m + i) % MEMB];
            if (rnd) chk(b == e, "R9 random read data", int'(b), int'(e));
            else chk(b == e, "R8 current address data", int'(b), int'(e));
        end
        chk(pull == 1'b0, "R10 released after host nack", int'(pull), 0);
        stop_c();
        ptr_m = (ptr_m + n) % MEMB;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] b;
        void'($urandom(32'd7219));
        for (int i = 0; i < MEMB; i++) mem_m[i] = 8'hFF;
        wt(5);
        chk(pull == 1'b0, "R3 reset pull released", int'(pull), 0);
        chk(busy == 1'b0, "R11 reset not busy", int'(busy), 0);
        rst_n = 1'b1;
        wt(4);

        // R2: no START seen yet, a matching byte must be ignored
        m_scl = 1'b0; wt(H);
        send_byte(8'hA0, a);
        chk(a == 1'b0, "R2 byte without start", int'(a), 0);
        stop_c();

        // R1: wrong device id, then following byte ignored
        start_c();
        send_byte(8'hB0, a);
        chk(a == 1'b0, "R1 foreign id nack", int'(a), 0);
        send_byte(8'hA0, a);
        chk(a == 1'b0, "R1 ignored until next start", int'(a), 0);
        stop_c();

        // Byte write, then random read back (R5, R9)
        do_write(32'h123, 1, 1'b0, 1'b0);
        do_read(1'b1, 32'h123, 1);

        // R4: page wrap from offset 14, 20 bytes
        do_write(32'h3FE, 20, 1'b0, 1'b0);
        do_read(1'b1, 32'h3F0, 16);
        chk(mem_m[32'h400] == 8'hFF, "R4 next page untouched", int'(mem_m[32'h400]), 255);
        do_read(1'b1, 32'h400, 1);

        // R6 and R7: protected writes leave memory alone
        do_write(32'h050, 3, 1'b1, 1'b0);
        do_read(1'b1, 32'h050, 2);
        do_write(32'h060, 2, 1'b0, 1'b1);
        do_read(1'b1, 32'h060, 2);

        // R11: address-only write starts no cycle but moves the pointer
        start_c();
        send_byte(8'hAE, a);
        chk(a, "R11 address ack", int'(a), 1);
        send_byte(8'h21, a);
        chk(a, "R11 memory address ack", int'(a), 1);
        stop_c();
        chk(busy == 1'b0, "R11 stop without data", int'(busy), 0);
        ptr_m = 32'h721;
        do_read(1'b0, 0, 2);

        // R8: wrap across the top of memory, then continue from the pointer
        do_write(32'h7FF, 1, 1'b0, 1'b0);
        do_write(32'h000, 2, 1'b0, 1'b0);
        do_read(1'b1, 32'h7FE, 4);
        do_read(1'b0, 0, 3);

        // R9: high address bits select distinct locations
        do_write(32'h7A0, 1, 1'b0, 1'b0);
        do_write(32'h0A0, 1, 1'b0, 1'b0);
        do_read(1'b1, 32'h7A0, 1);
        do_read(1'b1, 32'h0A0, 1);

        // Random mix
        for (int it = 0; it < 10; it++) begin
            int ad, nb;
            ad = int'($urandom % MEMB);
            nb = 1 + int'($urandom % 20);
            do_write(ad, nb, 1'b0, 1'b0);
            if ($urandom % 2) do_read(1'b0, 0, 1 + int'($urandom % 8));
            else do_read(1'b1, int'($urandom % MEMB), 1 + int'($urandom % 8));
        end

        chk(viol == 0, "R12 sda moved while scl high", viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule